// File: doc/BRIEF.md
# Channel-Change Playback Selector

This block chooses the word sent to the display whenever the viewer changes channel. The stream being watched always arrives on lane 0 of the live input group. Each lane 0 beat carries a channel tag, and the block shows only beats whose tag matches the channel currently selected. The other live lanes carry low-resolution copies of neighbouring channels. Those copies are written into a local buffer outside this block. The block records which channel identifiers have data in that buffer.

When a channel-change request arrives, the block checks its presence record. On a hit, it asks the buffer to stream that channel and shows the buffered words. It keeps doing so until the first live beat tagged with the new channel arrives, and from that beat on it shows live data again. On a miss, it tells the buffer to flush, clears its presence record, shows nothing and waits for the live stream. The display word passes through two selectors. The first chooses between a buffered word and a fixed fill word. The second chooses between that result and the live lane 0 word. The output is registered, so the display always sees whole words taken from a single source.

Top module: `chan_zap_player`

## Requirements
- R1: After reset, dispValid is 0, dispData equals FILL_WORD, curChan is 0, bufRdEn is 0, and no channel is recorded as buffered, so the first request is a miss.
- R2: When no request is pending and no playback is active, a valid lane 0 beat whose tag equals curChan appears on dispData one cycle later, with dispValid=1 and dispFromBuf=0. A lane 0 beat with any other tag is not displayed.
- R3: In a cycle where reqValid=1, no word is selected for display, so dispValid is 0 in the next cycle. From the next cycle on, curChan equals reqChan.
- R4: A request for a recorded channel enters playback. bufRdEn is then 1 and bufRdChan equals curChan. Each word with bufValid=1 appears on dispData one cycle later with dispFromBuf=1. Lane 0 beats tagged with another channel are ignored.
- R5: During playback, the first valid lane 0 beat tagged with curChan is displayed live with dispFromBuf=0, even when a buffered word arrives in the same cycle. Playback then ends and bufRdEn returns to 0.
- R6: A request for a channel that is not recorded drives bufFlush to 1 in the request cycle, with no clock delay. Nothing is then displayed until a lane 0 beat tagged with the new channel arrives, and that beat is shown live.
- R7: A valid beat on neighbour lane k (k = 1 to LANES-1) records the channel in its tag field, bits [(k-1)*CHAN_W +: CHAN_W] of nbrTag. A flush clears every record, and the flush wins over records set in the same cycle.
- R8: A request that arrives during playback or during the wait for live data restarts the hit/miss check with the new channel.
- R9: Whenever dispValid is 0, dispData equals FILL_WORD. This includes playback cycles that have no buffered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Channel-change request strobe |
| reqChan | input | CHAN_W | Requested channel identifier |
| liveValid | input | 1 | Lane 0 beat valid |
| liveTag | input | CHAN_W | Channel tag of the lane 0 beat |
| liveData | input | DATA_W | Lane 0 data word |
| nbrValid | input | LANES-1 | Valid flags of neighbour lanes 1 to LANES-1 |
| nbrTag | input | (LANES-1)*CHAN_W | Channel tags of the neighbour lanes, lane k at [(k-1)*CHAN_W +: CHAN_W] |
| bufValid | input | 1 | Buffered word valid |
| bufData | input | DATA_W | Buffered word from local memory |
| bufRdEn | output | 1 | Asks the buffer to stream bufRdChan |
| bufRdChan | output | CHAN_W | Channel to stream from the buffer |
| bufFlush | output | 1 | Flush strobe to the buffer |
| curChan | output | CHAN_W | Channel currently selected |
| dispValid | output | 1 | Display word valid |
| dispData | output | DATA_W | Display word |
| dispFromBuf | output | 1 | Display word came from the buffer |

## Verification
The bench uses the default parameters: eight lanes, giving seven neighbour lanes, a 4-bit channel tag with 16 identifiers, and 8-bit words. With seven neighbour lanes, one beat can record several channels at once. This allows a single request to test whether a flush clears records that were set in that same cycle. The 16 identifiers leave enough unused tags to include both a neighbour channel that was never recorded and stale live beats. Those beats must stay off the display during playback and during the wait for live data.

// File: rtl/zap_pkg.sv
package zap_pkg;

  typedef enum logic [1:0] {
    IDLE_LIVE = 2'd0,
    PLAYBACK  = 2'd1,
    WAIT_LIVE = 2'd2
  } zapState_t;

  // control-to-datapath strobes, valid for the current cycle
  typedef struct packed {
    logic showLive;
    logic showBuf;
    logic flush;
  } zapStrobe_t;

endpackage

// File: rtl/zap_presence.sv
module zap_presence
  import zap_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int CHAN_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [LANES-2:0]              nbrValid,
  input  logic [(LANES-1)*CHAN_W-1:0]   nbrTag,
  input  logic                          flush,
  output logic [(1<<CHAN_W)-1:0]        presentVec
);

  localparam int NUM_CH = 1 << CHAN_W;
  localparam int NBR    = LANES - 1;

  logic [NUM_CH-1:0] laneSet [NBR];
  logic [NUM_CH-1:0] setVec;

  genvar k;
  generate
    for (k = 0; k < NBR; k++) begin : g_lane
      always_comb begin
        laneSet[k] = '0;
        if (nbrValid[k]) laneSet[k][nbrTag[k*CHAN_W +: CHAN_W]] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    setVec = '0;
    for (int i = 0; i < NBR; i++) setVec = setVec | laneSet[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)      presentVec <= '0;
    else if (flush) presentVec <= '0;
    else            presentVec <= presentVec | setVec;
  end

  // R7: a flush leaves no channel recorded
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (presentVec == '0));

  // R7: a neighbour beat without flush records its channel
  p_nbr_records_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && nbrValid[0]) |=> presentVec[$past(nbrTag[CHAN_W-1:0])]);

endmodule

// File: rtl/zap_ctrl.sv
module zap_ctrl
  import zap_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [CHAN_W-1:0]       reqChan,
  input  logic                    liveValid,
  input  logic [CHAN_W-1:0]       liveTag,
  input  logic                    bufValid,
  input  logic [(1<<CHAN_W)-1:0]  presentVec,
  output zapStrobe_t              strobe,
  output logic [CHAN_W-1:0]       curChan,
  output logic                    bufRdEn
);

  zapState_t state, nextState;
  logic      liveHit;
  logic      reqHit;

  assign liveHit = liveValid && (liveTag == curChan);
  assign reqHit  = presentVec[reqChan];

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (reqValid) begin
      nextState    = reqHit ? PLAYBACK : WAIT_LIVE;
      strobe.flush = !reqHit;
    end else begin
      unique case (state)
        IDLE_LIVE: strobe.showLive = liveHit;
        PLAYBACK: begin
          if (liveHit) begin
            strobe.showLive = 1'b1;
            nextState       = IDLE_LIVE;
          end else begin
            strobe.showBuf = bufValid;
          end
        end
        WAIT_LIVE: begin
          if (liveHit) begin
            strobe.showLive = 1'b1;
            nextState       = IDLE_LIVE;
          end
        end
        default: nextState = IDLE_LIVE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE_LIVE;
      curChan <= '0;
    end else begin
      state <= nextState;
      if (reqValid) curChan <= reqChan;
    end
  end

  assign bufRdEn = (state == PLAYBACK);

  // R4, R8: a recorded channel leads to playback of that channel
  p_hit_playback_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && presentVec[reqChan]) |=> (state == PLAYBACK) && (curChan == $past(reqChan)));

  // R6, R8: an unrecorded channel leads to waiting for live data
  p_miss_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !presentVec[reqChan]) |=> (state == WAIT_LIVE));

  // R5: the matching live beat ends playback
  p_handover_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == PLAYBACK && !reqValid && liveValid && liveTag == curChan) |=> (state == IDLE_LIVE));

  // R3: the channel only changes through a request
  p_chan_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(curChan));

endmodule

// File: rtl/zap_datapath.sv
module zap_datapath
  import zap_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] FILL_WORD = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  zapStrobe_t        strobe,
  input  logic [DATA_W-1:0] liveData,
  input  logic [DATA_W-1:0] bufData,
  output logic              dispValid,
  output logic [DATA_W-1:0] dispData,
  output logic              dispFromBuf
);

  logic [DATA_W-1:0] bufStage;   // buffered word or fill word
  logic [DATA_W-1:0] finalStage; // live word or buffer stage

  assign bufStage   = strobe.showBuf  ? bufData  : FILL_WORD;
  assign finalStage = strobe.showLive ? liveData : bufStage;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispValid   <= 1'b0;
      dispData    <= FILL_WORD;
      dispFromBuf <= 1'b0;
    end else begin
      dispValid   <= strobe.showLive || strobe.showBuf;
      dispData    <= finalStage;
      dispFromBuf <= strobe.showBuf && !strobe.showLive;
    end
  end

  // R9: an empty display slot carries the fill word
  p_fill_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dispValid |-> (dispData == FILL_WORD));

  // R5: a word never comes from both sources
  p_one_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    dispFromBuf |-> dispValid);

endmodule

// File: rtl/chan_zap_player.sv
module chan_zap_player
  import zap_pkg::*;
#(
  parameter int              LANES     = 8,
  parameter int              DATA_W    = 8,
  parameter int              CHAN_W    = 4,
  parameter logic [DATA_W-1:0] FILL_WORD = 8'h10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [CHAN_W-1:0]           reqChan,
  input  logic                        liveValid,
  input  logic [CHAN_W-1:0]           liveTag,
  input  logic [DATA_W-1:0]           liveData,
  input  logic [LANES-2:0]            nbrValid,
  input  logic [(LANES-1)*CHAN_W-1:0] nbrTag,
  input  logic                        bufValid,
  input  logic [DATA_W-1:0]           bufData,
  output logic                        bufRdEn,
  output logic [CHAN_W-1:0]           bufRdChan,
  output logic                        bufFlush,
  output logic [CHAN_W-1:0]           curChan,
  output logic                        dispValid,
  output logic [DATA_W-1:0]           dispData,
  output logic                        dispFromBuf
);

  localparam int NUM_CH = 1 << CHAN_W;

  zapStrobe_t        strobe;
  logic [NUM_CH-1:0] presentVec;

  zap_presence #(.LANES(LANES), .CHAN_W(CHAN_W)) u_presence (
    .clk        (clk),
    .rstN       (rstN),
    .nbrValid   (nbrValid),
    .nbrTag     (nbrTag),
    .flush      (strobe.flush),
    .presentVec (presentVec)
  );

  zap_ctrl #(.CHAN_W(CHAN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqChan    (reqChan),
    .liveValid  (liveValid),
    .liveTag    (liveTag),
    .bufValid   (bufValid),
    .presentVec (presentVec),
    .strobe     (strobe),
    .curChan    (curChan),
    .bufRdEn    (bufRdEn)
  );

  zap_datapath #(.DATA_W(DATA_W), .FILL_WORD(FILL_WORD)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .liveData    (liveData),
    .bufData     (bufData),
    .dispValid   (dispValid),
    .dispData    (dispData),
    .dispFromBuf (dispFromBuf)
  );

  assign bufRdChan = curChan;
  assign bufFlush  = strobe.flush;

  // R3: a request cycle shows nothing
  p_blank_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !dispValid);

  // R4: buffered words only appear while the buffer is being read
  p_buf_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    dispFromBuf |-> $past(bufRdEn));

endmodule

// File: tb/sim_chan_zap_player.sv
`timescale 1ns/1ps
module sim_chan_zap_player;

  localparam int LANES  = 8;
  localparam int DATA_W = 8;
  localparam int CHAN_W = 4;
  localparam logic [DATA_W-1:0] FILL = 8'h10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [CHAN_W-1:0] reqChan = '0;
  logic liveValid = 1'b0;
  logic [CHAN_W-1:0] liveTag = '0;
  logic [DATA_W-1:0] liveData = '0;
  logic [LANES-2:0] nbrValid = '0;
  logic [(LANES-1)*CHAN_W-1:0] nbrTag = '0;
  logic bufValid = 1'b0;
  logic [DATA_W-1:0] bufData = '0;
  logic bufRdEn, bufFlush, dispValid, dispFromBuf;
  logic [CHAN_W-1:0] bufRdChan, curChan;
  logic [DATA_W-1:0] dispData;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chan_zap_player #(.LANES(LANES), .DATA_W(DATA_W), .CHAN_W(CHAN_W), .FILL_WORD(FILL)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .liveValid(liveValid), .liveTag(liveTag), .liveData(liveData),
    .nbrValid(nbrValid), .nbrTag(nbrTag), .bufValid(bufValid), .bufData(bufData),
    .bufRdEn(bufRdEn), .bufRdChan(bufRdChan), .bufFlush(bufFlush), .curChan(curChan),
    .dispValid(dispValid), .dispData(dispData), .dispFromBuf(dispFromBuf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    reqValid = 0; liveValid = 0; nbrValid = '0; bufValid = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    clearIn();
  endtask

  task automatic setNbr(input int lane, input logic [CHAN_W-1:0] tag);
    nbrValid[lane-1] = 1'b1;
    nbrTag[(lane-1)*CHAN_W +: CHAN_W] = tag;
  endtask

  task automatic live(input logic [CHAN_W-1:0] tag, input logic [DATA_W-1:0] d);
    liveValid = 1; liveTag = tag; liveData = d;
  endtask

  task automatic request(input logic [CHAN_W-1:0] ch);
    reqValid = 1; reqChan = ch;
  endtask

  task automatic expectDisp(input string req, input logic v, input logic [DATA_W-1:0] d,
                            input logic fb);
    check({req, " dispValid"}, 32'(dispValid), 32'(v));
    check({req, " dispData"}, 32'(dispData), 32'(d));
    check({req, " dispFromBuf"}, 32'(dispFromBuf), 32'(fb));
  endtask

  task automatic testReset();
    check("R1 dispValid", 32'(dispValid), 0);
    check("R1 dispData", 32'(dispData), 32'(FILL));
    check("R1 curChan", 32'(curChan), 0);
    check("R1 bufRdEn", 32'(bufRdEn), 0);
    request(4'd2); #1;
    check("R1 empty record gives flush", 32'(bufFlush), 1);
    tick();
    live(4'd2, 8'h22); tick();
  endtask

  task automatic testLive();
    live(4'd2, 8'h31); tick();
    expectDisp("R2 matching live", 1, 8'h31, 0);
    live(4'd5, 8'h32); tick();
    expectDisp("R2 other tag", 0, FILL, 0);
  endtask

  task automatic testHit();
    setNbr(1, 4'd3); setNbr(6, 4'd9); tick();
    request(4'd3); live(4'd2, 8'h40); #1;
    check("R4 no flush on hit", 32'(bufFlush), 0);
    tick();
    expectDisp("R3 request blanks", 0, FILL, 0);
    check("R3 curChan", 32'(curChan), 3);
    check("R4 bufRdEn", 32'(bufRdEn), 1);
    check("R4 bufRdChan", 32'(bufRdChan), 3);
    bufValid = 1; bufData = 8'hA1; live(4'd2, 8'h41); tick();
    expectDisp("R4 buffered word", 1, 8'hA1, 1);
    tick();
    expectDisp("R9 playback gap", 0, FILL, 0);
    bufValid = 1; bufData = 8'hB2; live(4'd3, 8'h55); tick();
    expectDisp("R5 live wins", 1, 8'h55, 0);
    check("R5 bufRdEn off", 32'(bufRdEn), 0);
    bufValid = 1; bufData = 8'hC3; tick();
    expectDisp("R5 buffer ignored after handover", 0, FILL, 0);
  endtask

  task automatic testMiss();
    request(4'd12); setNbr(2, 4'd4); setNbr(7, 4'd11); #1;
    check("R6 flush strobe", 32'(bufFlush), 1);
    tick();
    check("R6 no buffer read", 32'(bufRdEn), 0);
    live(4'd3, 8'h60); tick();
    expectDisp("R6 stale live hidden", 0, FILL, 0);
    live(4'd12, 8'h61); tick();
    expectDisp("R6 live after wait", 1, 8'h61, 0);
    request(4'd9); #1;
    check("R7 earlier record flushed", 32'(bufFlush), 1);
    tick();
    request(4'd4); #1;
    check("R7 flush beats same-cycle set", 32'(bufFlush), 1);
    tick();
  endtask

  task automatic testRestart();
    setNbr(3, 4'd6); setNbr(4, 4'd8); tick();
    request(4'd6); tick();
    check("R8 first playback", 32'(bufRdChan), 6);
    request(4'd8); #1;
    check("R8 hit inside playback", 32'(bufFlush), 0);
    tick();
    check("R8 restarted channel", 32'(bufRdChan), 8);
    check("R8 still playback", 32'(bufRdEn), 1);
    bufValid = 1; bufData = 8'hD4; tick();
    expectDisp("R8 buffered after restart", 1, 8'hD4, 1);
    request(4'd7); #1;
    check("R8 miss inside playback", 32'(bufFlush), 1);
    tick();
    check("R8 playback left", 32'(bufRdEn), 0);
    setNbr(5, 4'd1); tick();
    request(4'd1); tick();
    check("R8 hit from wait", 32'(bufRdEn), 1);
    live(4'd1, 8'h77); tick();
    expectDisp("R5 handover from restart", 1, 8'h77, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testLive();
    testHit();
    testMiss();
    testRestart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule